// File: doc/BRIEF.md
# Filtered SPI Configuration Register Bank

This block is a write-mostly serial slave that holds five small control registers: a band-pass frequency code, a gain code, an integrator time-constant code, a prescaler code and a test/channel word. A host sends 8-bit command words over a three-wire serial link: chip select active low, a serial clock, and serial data in. The block oversamples all serial pins in its own system clock domain, so the serial clock may run at up to one quarter of the system clock rate.

Before a word reaches a register, a framing filter checks the whole transaction. The serial clock must be low when chip select falls. There must be exactly eight rising serial clock edges, which with the low start and low end make eight full low-high-low pulses. The serial clock must again be low when chip select rises. Only then is the word committed, on the rising edge of chip select, to the register named by its top three bits. Any other transaction leaves no trace. A failed frame is flushed at the next chip select fall, so the next frame starts from a clean counter and buffer.

A diagnostic output drives the serial data-out pin while a frame is active. A two-bit source field in the test/channel register picks what it carries: the contents of the register written most recently, shifted out serially; a buffered echo of serial data in; or an external comparator bit.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset every configuration output and `amp_chan` is zero, `spi_so_oe` is 0 and `spi_so` is at the idle level, which is 0 by default.
- R2: A valid frame commits its word when chip select rises. In a valid frame SCK is low when CS falls, SI is sampled on 8 rising SCK edges MSB first, and SCK is low when CS rises. Bits [7:5] are the address and bits [4:0] the data. The addresses map as 0 = bpf, 1 = gain, 2 = integ, 3 = presc, 4 = test.
- R3: A valid frame with address 5, 6 or 7 changes no register.
- R4: A frame with fewer or more than 8 rising SCK edges is discarded, and every register keeps its value.
- R5: A frame in which SCK is high at the moment CS falls is discarded, even if exactly 8 pulses follow.
- R6: A frame in which SCK is high at the moment CS rises is discarded, even if it contains exactly 8 rising edges.
- R7: After an aborted frame, the next valid frame commits correctly. No bits and no pulse count carry over from the aborted frame.
- R8: Test register bit 0 drives `amp_chan`. Test register bits [2:1] select the SO source: 00 or 11 = register readback, 01 = echo of SI, 10 = comparator input.
- R9: In readback mode, CS falling loads the 8-bit value {ptr, reg[ptr]}. Here ptr is the address of the most recent valid commit to addresses 0 to 4, and ptr is 0 after reset. SO presents bit 7 first and advances one bit on each SCK falling edge.
- R10: `spi_so_oe` is 1 only while a frame is active, meaning from CS fall to CS rise after synchronization. While it is 0, `spi_so` sits at the idle level whatever source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| cmp_in | input | 1 | External comparator bit for diagnostics |
| spi_so | output | 1 | Diagnostic serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so |
| bpf_code | output | 5 | Band-pass frequency code (address 0) |
| gain_code | output | 5 | Gain/attenuation code (address 1) |
| integ_code | output | 5 | Integrator time-constant code (address 2) |
| presc_code | output | 5 | Prescaler code (address 3) |
| test_code | output | 5 | Test/channel word (address 4) |
| amp_chan | output | 1 | Input amplifier channel select, test bit 0 |

## Verification
The framing filter is tried with five kinds of frame. The first is clean 8-pulse frames to every address, which shows that each decoded address reaches its own register. The next are frames with 7 and 9 pulses, which show that the counter separates short and long frames from exact ones. Frames whose SCK is high at the CS fall or at the CS rise, each with otherwise correct pulse counts, isolate the two edge conditions from the count check. An aborted partial frame followed by a clean one shows whether stale count or data leaks across frames. The three SO sources are each driven with known values while CS is low and while it is high, which separates the source selection from the output-enable gating.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

   localparam int REG_COUNT = 5;

   localparam int IDX_BPF   = 0;
   localparam int IDX_GAIN  = 1;
   localparam int IDX_INTEG = 2;
   localparam int IDX_PRESC = 3;
   localparam int IDX_TEST  = 4;

   typedef enum logic [1:0] {
      SO_READBACK  = 2'b00,
      SO_ECHO      = 2'b01,
      SO_CMP       = 2'b10,
      SO_READBACK2 = 2'b11
   } so_src_e;

endpackage

// File: rtl/spicfg_sync.sv
module spicfg_sync #(
   parameter int          WIDTH   = 4,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("spicfg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spicfg_frame.sv
module spicfg_frame #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sck_s,
   input  logic              si_s,
   output logic              active,
   output logic              start,
   output logic              sck_fall,
   output logic              commit_v,
   output logic [WORD_W-1:0] commit_word
);

   localparam int CNT_W   = $clog2(WORD_W + 2);
   localparam int CNT_MAX = WORD_W + 1;

   logic              cs_q, sck_q;
   logic              clean_start;
   logic [CNT_W-1:0]  edge_cnt;
   logic [WORD_W-1:0] shbuf;
   logic              cs_rise, sck_rise;

   assign start    = cs_q & ~cs_s;
   assign cs_rise  = ~cs_q & cs_s;
   assign sck_rise = ~sck_q & sck_s;
   assign sck_fall = sck_q & ~sck_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q        <= 1'b1;
         sck_q       <= 1'b0;
         active      <= 1'b0;
         clean_start <= 1'b0;
         edge_cnt    <= '0;
         shbuf       <= '0;
         commit_v    <= 1'b0;
         commit_word <= '0;
      end else begin
         cs_q     <= cs_s;
         sck_q    <= sck_s;
         commit_v <= 1'b0;
         if (start) begin
            active      <= 1'b1;
            clean_start <= ~sck_s;
            edge_cnt    <= '0;
            shbuf       <= '0;
         end else if (active) begin
            if (cs_rise) begin
               active <= 1'b0;
               if (clean_start && !sck_s && edge_cnt == CNT_W'(WORD_W)) begin
                  commit_v    <= 1'b1;
                  commit_word <= shbuf;
               end
            end else if (sck_rise) begin
               shbuf <= {shbuf[WORD_W-2:0], si_s};
               if (edge_cnt != CNT_W'(CNT_MAX)) begin
                  edge_cnt <= edge_cnt + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/spicfg_regs.sv
module spicfg_regs #(
   parameter int NUM_REGS = 5,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       commit_v,
   input  logic [ADDR_W+DATA_W-1:0]   commit_word,
   output logic [NUM_REGS-1:0]        wen,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   logic [ADDR_W-1:0] waddr;
   logic [DATA_W-1:0] wdata;

   assign waddr = commit_word[ADDR_W+DATA_W-1:DATA_W];
   assign wdata = commit_word[DATA_W-1:0];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         assign wen[i] = commit_v && (waddr == ADDR_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs_flat[i*DATA_W +: DATA_W] <= '0;
            end else if (wen[i]) begin
               regs_flat[i*DATA_W +: DATA_W] <= wdata;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/spicfg_diag.sv
module spicfg_diag
   import spicfg_pkg::*;
#(
   parameter int   NUM_REGS = 5,
   parameter int   ADDR_W   = 3,
   parameter int   DATA_W   = 5,
   parameter logic IDLE_SO  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       active,
   input  logic                       start,
   input  logic                       sck_fall,
   input  logic                       commit_v,
   input  logic [ADDR_W+DATA_W-1:0]   commit_word,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   input  logic [1:0]                 src,
   input  logic                       si_s,
   input  logic                       cmp_s,
   output logic                       so,
   output logic                       so_oe
);

   localparam int WORD_W = ADDR_W + DATA_W;

   logic [ADDR_W-1:0] ptr;
   logic [DATA_W-1:0] sel_reg;
   logic [WORD_W-1:0] rb_sh;
   logic [ADDR_W-1:0] c_addr;

   assign c_addr = commit_word[WORD_W-1:DATA_W];

   always_comb begin
      sel_reg = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (ptr == ADDR_W'(i)) sel_reg = regs_flat[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         rb_sh <= '0;
      end else begin
         if (commit_v && (c_addr < ADDR_W'(NUM_REGS))) ptr <= c_addr;
         if (start) begin
            rb_sh <= {ptr, sel_reg};
         end else if (active && sck_fall) begin
            rb_sh <= {rb_sh[WORD_W-2:0], 1'b0};
         end
      end
   end

   assign so_oe = active;

   always_comb begin
      if (!active) begin
         so = IDLE_SO;
      end else begin
         unique case (so_src_e'(src))
            SO_ECHO:  so = si_s;
            SO_CMP:   so = cmp_s;
            default:  so = rb_sh[WORD_W-1];
         endcase
      end
   end

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
   import spicfg_pkg::*;
#(
   parameter int   WORD_W      = 8,
   parameter int   ADDR_W      = 3,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_SO     = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_cs_n,
   input  logic                       spi_sck,
   input  logic                       spi_si,
   input  logic                       cmp_in,
   output logic                       spi_so,
   output logic                       spi_so_oe,
   output logic [WORD_W-ADDR_W-1:0]   bpf_code,
   output logic [WORD_W-ADDR_W-1:0]   gain_code,
   output logic [WORD_W-ADDR_W-1:0]   integ_code,
   output logic [WORD_W-ADDR_W-1:0]   presc_code,
   output logic [WORD_W-ADDR_W-1:0]   test_code,
   output logic                       amp_chan
);

   localparam int DATA_W   = WORD_W - ADDR_W;
   localparam int NUM_REGS = REG_COUNT;
   localparam int FLAT_W   = NUM_REGS * DATA_W;

   generate
      if ((2 ** ADDR_W) < NUM_REGS) begin : g_chk_addr
         $error("spi_cfg_bank: ADDR_W too narrow for the register count");
      end
      if (DATA_W < 3) begin : g_chk_data
         $error("spi_cfg_bank: data field must hold channel and source bits");
      end
   endgenerate

   logic [3:0]          sync_q;
   logic                sync_cs, sync_sck, sync_si, sync_cmp;
   logic                active, start, sck_fall, commit_v;
   logic [WORD_W-1:0]   commit_word;
   logic [NUM_REGS-1:0] wen;
   logic [FLAT_W-1:0]   regs_flat;

   spicfg_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b0001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cmp_in, spi_si, spi_sck, spi_cs_n}),
      .q     (sync_q)
   );

   assign sync_cs  = sync_q[0];
   assign sync_sck = sync_q[1];
   assign sync_si  = sync_q[2];
   assign sync_cmp = sync_q[3];

   spicfg_frame #(
      .WORD_W (WORD_W)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_s        (sync_cs),
      .sck_s       (sync_sck),
      .si_s        (sync_si),
      .active      (active),
      .start       (start),
      .sck_fall    (sck_fall),
      .commit_v    (commit_v),
      .commit_word (commit_word)
   );

   spicfg_regs #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_v    (commit_v),
      .commit_word (commit_word),
      .wen         (wen),
      .regs_flat   (regs_flat)
   );

   assign bpf_code   = regs_flat[IDX_BPF*DATA_W   +: DATA_W];
   assign gain_code  = regs_flat[IDX_GAIN*DATA_W  +: DATA_W];
   assign integ_code = regs_flat[IDX_INTEG*DATA_W +: DATA_W];
   assign presc_code = regs_flat[IDX_PRESC*DATA_W +: DATA_W];
   assign test_code  = regs_flat[IDX_TEST*DATA_W  +: DATA_W];
   assign amp_chan   = test_code[0];

   spicfg_diag #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .IDLE_SO  (IDLE_SO)
   ) u_diag (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .start       (start),
      .sck_fall    (sck_fall),
      .commit_v    (commit_v),
      .commit_word (commit_word),
      .regs_flat   (regs_flat),
      .src         (test_code[2:1]),
      .si_s        (sync_si),
      .cmp_s       (sync_cmp),
      .so          (spi_so),
      .so_oe       (spi_so_oe)
   );

endmodule

// File: rtl/spicfg_chk.sv
module spicfg_chk #(
   parameter int   NREG    = 5,
   parameter int   ADDR_W  = 3,
   parameter int   WORD_W  = 8,
   parameter int   FLAT_W  = 25,
   parameter logic IDLE_SO = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              commit_v,
   input logic [WORD_W-1:0] commit_word,
   input logic [NREG-1:0]   wen,
   input logic              cs_s,
   input logic              sck_s,
   input logic [FLAT_W-1:0] regs_flat,
   input logic              so,
   input logic              so_oe
);

   // R2
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wen));

   // R2
   cs_high_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_v |-> $past(cs_s));

   // R6
   sck_low_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_v |-> !$past(sck_s));

   // R3
   bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_v && (commit_word[WORD_W-1 -: ADDR_W] >= ADDR_W'(NREG))) |=> $stable(regs_flat));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_v |=> $stable(regs_flat));

   // R10
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !so_oe |-> (so == IDLE_SO));

endmodule

bind spi_cfg_bank spicfg_chk #(
   .NREG    (NUM_REGS),
   .ADDR_W  (ADDR_W),
   .WORD_W  (WORD_W),
   .FLAT_W  (FLAT_W),
   .IDLE_SO (IDLE_SO)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .commit_v    (commit_v),
   .commit_word (commit_word),
   .wen         (wen),
   .cs_s        (sync_cs),
   .sck_s       (sync_sck),
   .regs_flat   (regs_flat),
   .so          (spi_so),
   .so_oe       (spi_so_oe)
);

// File: tb/spi_cfg_bank_bench.sv
module spi_cfg_bank_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0, cmp_in = 1'b0;
   logic spi_so, spi_so_oe, amp_chan;
   logic [4:0] bpf_code, gain_code, integ_code, presc_code, test_code;

   int n_chk = 0;
   int n_bad = 0;
   logic [4:0] exp_r [5];

   always #5 clk = ~clk;

   spi_cfg_bank u_spi_cfg_bank (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_si(spi_si), .cmp_in(cmp_in), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
      .bpf_code(bpf_code), .gain_code(gain_code), .integ_code(integ_code),
      .presc_code(presc_code), .test_code(test_code), .amp_chan(amp_chan)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      check({req, " bpf"},   bpf_code,   exp_r[0]);
      check({req, " gain"},  gain_code,  exp_r[1]);
      check({req, " integ"}, integ_code, exp_r[2]);
      check({req, " presc"}, presc_code, exp_r[3]);
      check({req, " test"},  test_code,  exp_r[4]);
   endtask

   task automatic xfer(input logic [7:0] w, input int npulse, input bit hi_fall,
                       input bit hi_rise, output logic [7:0] rb);
      rb = '0;
      spi_sck = hi_fall;
      tick(4);
      spi_cs_n = 1'b0;
      tick(4);
      if (hi_fall) begin
         spi_sck = 1'b0;
         tick(4);
      end
      for (int i = 0; i < npulse; i++) begin
         spi_si = (i < 8) ? w[7-i] : 1'b0;
         tick(4);
         if (i < 8) rb[7-i] = spi_so;
         spi_sck = 1'b1;
         tick(4);
         spi_sck = 1'b0;
         tick(4);
      end
      if (hi_rise) begin
         spi_sck = 1'b1;
         tick(4);
      end
      spi_cs_n = 1'b1;
      tick(4);
      spi_sck = 1'b0;
      spi_si = 1'b0;
      tick(8);
   endtask

   task automatic wr(input int a, input logic [4:0] d);
      logic [7:0] rb;
      xfer({3'(a), d}, 8, 1'b0, 1'b0, rb);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 5; i++) exp_r[i] = '0;
      check_regs("R1 reset");
      check("R1 amp_chan", amp_chan, 0);
      check("R1 so_oe", spi_so_oe, 0);
      check("R1 so idle", spi_so, 0);
   endtask

   task automatic t_write_all;
      exp_r[0] = 5'h15; exp_r[1] = 5'h0A; exp_r[2] = 5'h1F;
      exp_r[3] = 5'h03; exp_r[4] = 5'h18;
      for (int i = 0; i < 5; i++) wr(i, exp_r[i]);
      check_regs("R2 write");
   endtask

   task automatic t_bad_addr;
      wr(5, 5'h01);
      wr(6, 5'h0F);
      wr(7, 5'h1E);
      check_regs("R3 addr5-7");
   endtask

   task automatic t_count;
      logic [7:0] rb;
      xfer({3'd1, 5'h11}, 7, 1'b0, 1'b0, rb);
      check_regs("R4 seven pulses");
      xfer({3'd1, 5'h11}, 9, 1'b0, 1'b0, rb);
      check_regs("R4 nine pulses");
   endtask

   task automatic t_start_high;
      logic [7:0] rb;
      xfer({3'd2, 5'h04}, 8, 1'b1, 1'b0, rb);
      check_regs("R5 sck high at cs fall");
   endtask

   task automatic t_end_high;
      logic [7:0] rb;
      xfer({3'd3, 5'h1C}, 7, 1'b0, 1'b1, rb);
      check_regs("R6 sck high at cs rise");
   endtask

   task automatic t_recover;
      logic [7:0] rb;
      xfer({3'd2, 5'h1B}, 3, 1'b0, 1'b0, rb);
      check_regs("R7 aborted frame");
      wr(2, 5'h06);
      exp_r[2] = 5'h06;
      check_regs("R7 frame after abort");
   endtask

   task automatic t_readback;
      logic [7:0] rb;
      wr(3, 5'h19);
      exp_r[3] = 5'h19;
      xfer(8'hE0, 8, 1'b0, 1'b0, rb);
      check("R9 readback presc", rb, {3'd3, 5'h19});
      wr(4, 5'h06);
      exp_r[4] = 5'h06;
      xfer(8'hFF, 8, 1'b0, 1'b0, rb);
      check("R9 readback test src11", rb, {3'd4, 5'h06});
      check_regs("R3 dummy readback frames");
   endtask

   task automatic t_chan;
      wr(4, 5'h01);
      exp_r[4] = 5'h01;
      check("R8 amp_chan set", amp_chan, 1);
      wr(4, 5'h00);
      exp_r[4] = 5'h00;
      check("R8 amp_chan clear", amp_chan, 0);
   endtask

   task automatic t_echo;
      wr(4, 5'h02);
      exp_r[4] = 5'h02;
      spi_cs_n = 1'b0;
      tick(6);
      check("R10 oe in frame", spi_so_oe, 1);
      spi_si = 1'b1;
      tick(5);
      check("R8 echo 1", spi_so, 1);
      spi_si = 1'b0;
      tick(5);
      check("R8 echo 0", spi_so, 0);
      spi_cs_n = 1'b1;
      spi_si = 1'b1;
      tick(6);
      check("R10 oe idle", spi_so_oe, 0);
      check("R10 so idle with si high", spi_so, 0);
      spi_si = 1'b0;
      tick(4);
   endtask

   task automatic t_cmp;
      wr(4, 5'h04);
      exp_r[4] = 5'h04;
      spi_cs_n = 1'b0;
      cmp_in = 1'b1;
      tick(6);
      check("R8 comparator 1", spi_so, 1);
      cmp_in = 1'b0;
      tick(5);
      check("R8 comparator 0", spi_so, 0);
      cmp_in = 1'b1;
      spi_cs_n = 1'b1;
      tick(6);
      check("R10 so idle with cmp high", spi_so, 0);
      cmp_in = 1'b0;
      check_regs("R3 regs after diag");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_write_all();
      t_bad_addr();
      t_count();
      t_start_high();
      t_end_high();
      t_recover();
      t_readback();
      t_chan();
      t_echo();
      t_cmp();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule